// File: doc/BRIEF.md
# Bit-Manipulation Decode and Execute Unit

This unit sits beside the integer ALU of a 32-bit RISC-V core. Each cycle that `in_valid` is high it takes a raw instruction word and the two source operand values. It decodes the word against the basic bit-manipulation encodings and computes a 32-bit result. One cycle later it returns the result, the destination register index and an illegal flag. The operations it covers are the logical operations with an inverted second operand, the three bit counts, signed and unsigned min/max, sign and zero extension, rotates by register and by immediate, byte-wise OR-combine and byte reverse.

The decoder works directly on the opcode, funct3, funct7, funct6 and funct12 fields, including the encoding spaces that these operations share with other instructions. Any word that does not exactly match one of the supported encodings is flagged illegal, and its result is forced to zero. The caller does the register reads, the writeback and the hazard handling.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted word after it rises, `out_valid`, `out_result`, `out_rd` and `out_illegal` are all 0.
- R2: `out_valid` is `in_valid` delayed by exactly one clock, and `out_rd` then equals bits [11:7] of the accepted word. In a cycle with `in_valid` low, `out_result`, `out_rd` and `out_illegal` keep their previous values.
- R3: For opcode 0110011 with funct7 0100000, funct3 100 gives ~(a ^ b), funct3 110 gives a | ~b and funct3 111 gives a & ~b.
- R4: For opcode 0110011 with funct7 0000101, funct3 100 gives the signed minimum, 101 the unsigned minimum, 110 the signed maximum and 111 the unsigned maximum of the two operands.
- R5: For opcode 0010011 with funct3 001 and funct7 0110000, an rs2 field [24:20] of 0 gives the count of leading zeros, 1 the count of trailing zeros and 2 the population count. A zero operand gives 32 for both leading and trailing counts.
- R6: In the same group as R5, an rs2 field of 4 sign-extends bit 7 of the operand and 5 sign-extends bit 15. Field values 3 and 6 to 31 are illegal.
- R7: Opcode 0110011 with funct3 100 and funct7 0000100 zero-extends the low 16 bits of the operand when the rs2 field is 0. It is illegal for any other rs2 field value.
- R8: For opcode 0110011 with funct7 0110000, funct3 001 rotates left and funct3 101 rotates right. The amount is the low 5 bits of operand b.
- R9: Opcode 0010011 with funct3 101 and bits [31:26] equal to 011000 rotates right by the amount in bits [24:20], and operand b has no effect. If bit 25 is 1, the word is illegal.
- R10: Opcode 0010011 with funct3 101 and funct12 001010000111 sets each result byte to 0xFF when the matching operand byte is nonzero, and to 0x00 otherwise. With funct12 011010011000 it reverses the byte order.
- R11: An opcode other than 0010011 or 0110011, or any field combination not listed in R3 to R10, sets `out_illegal`, and the result is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word and operands are presented this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_rs1_val | input | 32 | First source operand value (a) |
| in_rs2_val | input | 32 | Second source operand value (b) |
| out_valid | output | 1 | Result registers hold a new result |
| out_result | output | 32 | Computed result, 0 when illegal |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Word matched no supported encoding |

## Verification
The hardest case to reach is the set of words that fall inside a shared encoding space but miss an exact match. Examples are the immediate-rotate pattern with bit 25 set, the count group with an unused rs2 selector, the zero-extend encoding with a nonzero rs2 field, and neighbouring shift and add encodings. None of these arise from ordinary operand patterns. The stimulus table builds each of them field by field, with nonzero operands, so that a decoder that lets one through shows a nonzero result or a clear illegal flag.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int ILEN = 32;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;

    localparam logic [6:0] F7_ROT  = 7'b0110000;
    localparam logic [6:0] F7_NEG  = 7'b0100000;
    localparam logic [6:0] F7_MNMX = 7'b0000101;
    localparam logic [6:0] F7_ZXT  = 7'b0000100;

    localparam logic [5:0]  F6_RORI  = 6'b011000;
    localparam logic [11:0] F12_ORCB = 12'b001010000111;
    localparam logic [11:0] F12_REV8 = 12'b011010011000;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_ANDN,
        OP_ORN,
        OP_XNOR,
        OP_CLZ,
        OP_CTZ,
        OP_CPOP,
        OP_MIN,
        OP_MINU,
        OP_MAX,
        OP_MAXU,
        OP_SEXTB,
        OP_SEXTH,
        OP_ZEXTH,
        OP_ROL,
        OP_ROR,
        OP_RORI,
        OP_ORCB,
        OP_REV8
    } bmu_op_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output bmu_op_e         op,
    output logic            illegal,
    output logic            use_imm,
    output logic [4:0]      rd_idx
);

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [5:0]  f6;
    logic [4:0]  sel;
    logic [11:0] f12;
    logic        unused_rs1;

    assign opc        = instr[6:0];
    assign rd_idx     = instr[11:7];
    assign f3         = instr[14:12];
    assign sel        = instr[24:20];
    assign f7         = instr[31:25];
    assign f6         = instr[31:26];
    assign f12        = instr[31:20];
    assign unused_rs1 = ^instr[19:15];

    always_comb begin
        op      = OP_NONE;
        use_imm = 1'b0;
        case (opc)
            OPC_IMM: begin
                case (f3)
                    3'b001: begin
                        if (f7 == F7_ROT) begin
                            case (sel)
                                5'd0:    op = OP_CLZ;
                                5'd1:    op = OP_CTZ;
                                5'd2:    op = OP_CPOP;
                                5'd4:    op = OP_SEXTB;
                                5'd5:    op = OP_SEXTH;
                                default: op = OP_NONE;
                            endcase
                        end
                    end
                    3'b101: begin
                        if (f12 == F12_ORCB) begin
                            op = OP_ORCB;
                        end else if (f12 == F12_REV8) begin
                            op = OP_REV8;
                        end else if (f6 == F6_RORI && !instr[25]) begin
                            op      = OP_RORI;
                            use_imm = 1'b1;
                        end
                    end
                    default: op = OP_NONE;
                endcase
            end
            OPC_REG: begin
                case (f7)
                    F7_ROT: begin
                        if (f3 == 3'b001)      op = OP_ROL;
                        else if (f3 == 3'b101) op = OP_ROR;
                    end
                    F7_NEG: begin
                        case (f3)
                            3'b100:  op = OP_XNOR;
                            3'b110:  op = OP_ORN;
                            3'b111:  op = OP_ANDN;
                            default: op = OP_NONE;
                        endcase
                    end
                    F7_MNMX: begin
                        case (f3)
                            3'b100:  op = OP_MIN;
                            3'b101:  op = OP_MINU;
                            3'b110:  op = OP_MAX;
                            3'b111:  op = OP_MAXU;
                            default: op = OP_NONE;
                        endcase
                    end
                    F7_ZXT: begin
                        if (f3 == 3'b100 && sel == 5'd0) op = OP_ZEXTH;
                    end
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
        illegal = (op == OP_NONE);
    end

endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]        x,
    output logic [$clog2(XLEN):0]  lead,
    output logic [$clog2(XLEN):0]  trail,
    output logic [$clog2(XLEN):0]  pop
);

    localparam int CW = $clog2(XLEN) + 1;

    always_comb begin
        lead = CW'(XLEN);
        for (int i = 0; i < XLEN; i++) begin
            if (x[i]) lead = CW'(XLEN - 1 - i);
        end
    end

    always_comb begin
        trail = CW'(XLEN);
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (x[i]) trail = CW'(i);
        end
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < XLEN; i++) begin
            pop = pop + CW'(x[i]);
        end
    end

endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] x,
    output logic [XLEN-1:0] orc,
    output logic [XLEN-1:0] rev
);

    localparam int NB = XLEN / 8;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign orc[8*g +: 8] = {8{|x[8*g +: 8]}};
        assign rev[8*g +: 8] = x[8*(NB-1-g) +: 8];
    end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]          x,
    input  logic [$clog2(XLEN)-1:0]  amt,
    input  logic                     left,
    output logic [XLEN-1:0]          y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]    amt_eff;
    logic [2*XLEN-1:0] dbl;

    always_comb begin
        amt_eff = left ? (SHW'(0) - amt) : amt;
        dbl     = {x, x} >> amt_eff;
        y       = dbl[XLEN-1:0];
    end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bmu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_rs1_val,
    input  logic [XLEN-1:0] in_rs2_val,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic [4:0]      out_rd,
    output logic            out_illegal
);

    localparam int SHW = $clog2(XLEN);
    localparam int CW  = SHW + 1;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic [4:0]      rd;
        logic            ill;
    } state_t;

    state_t st_d, st_q;

    bmu_op_e         op;
    logic            dec_ill;
    logic            use_imm;
    logic [4:0]      rd_idx;
    logic [CW-1:0]   cnt_lead, cnt_trail, cnt_pop;
    logic [XLEN-1:0] orc_val, rev_val, rot_val;
    logic [SHW-1:0]  rot_amt;
    logic            rot_left;
    logic [XLEN-1:0] exec_val;

    bmu_decode u_dec (
        .instr   (in_instr),
        .op      (op),
        .illegal (dec_ill),
        .use_imm (use_imm),
        .rd_idx  (rd_idx)
    );

    bmu_count #(.XLEN(XLEN)) u_cnt (
        .x     (in_rs1_val),
        .lead  (cnt_lead),
        .trail (cnt_trail),
        .pop   (cnt_pop)
    );

    bmu_bytes #(.XLEN(XLEN)) u_byt (
        .x   (in_rs1_val),
        .orc (orc_val),
        .rev (rev_val)
    );

    assign rot_amt  = use_imm ? in_instr[20 +: SHW] : in_rs2_val[SHW-1:0];
    assign rot_left = (op == OP_ROL);

    bmu_rotate #(.XLEN(XLEN)) u_rot (
        .x    (in_rs1_val),
        .amt  (rot_amt),
        .left (rot_left),
        .y    (rot_val)
    );

    always_comb begin
        logic s_lt, u_lt;
        s_lt     = $signed(in_rs1_val) < $signed(in_rs2_val);
        u_lt     = in_rs1_val < in_rs2_val;
        exec_val = '0;
        case (op)
            OP_ANDN:  exec_val = in_rs1_val & ~in_rs2_val;
            OP_ORN:   exec_val = in_rs1_val | ~in_rs2_val;
            OP_XNOR:  exec_val = ~(in_rs1_val ^ in_rs2_val);
            OP_CLZ:   exec_val = XLEN'(cnt_lead);
            OP_CTZ:   exec_val = XLEN'(cnt_trail);
            OP_CPOP:  exec_val = XLEN'(cnt_pop);
            OP_MIN:   exec_val = s_lt ? in_rs1_val : in_rs2_val;
            OP_MINU:  exec_val = u_lt ? in_rs1_val : in_rs2_val;
            OP_MAX:   exec_val = s_lt ? in_rs2_val : in_rs1_val;
            OP_MAXU:  exec_val = u_lt ? in_rs2_val : in_rs1_val;
            OP_SEXTB: exec_val = {{(XLEN-8){in_rs1_val[7]}}, in_rs1_val[7:0]};
            OP_SEXTH: exec_val = {{(XLEN-16){in_rs1_val[15]}}, in_rs1_val[15:0]};
            OP_ZEXTH: exec_val = {{(XLEN-16){1'b0}}, in_rs1_val[15:0]};
            OP_ROL,
            OP_ROR,
            OP_RORI:  exec_val = rot_val;
            OP_ORCB:  exec_val = orc_val;
            OP_REV8:  exec_val = rev_val;
            default:  exec_val = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.rd  = rd_idx;
            st_d.ill = dec_ill;
            st_d.res = dec_ill ? '0 : exec_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_result  = st_q.res;
    assign out_rd      = st_q.rd;
    assign out_illegal = st_q.ill;

endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     in_instr,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic [4:0]      out_rd,
    input logic            out_illegal
);

    logic unused_chk;
    assign unused_chk = ^in_instr[19:15];

    logic count_word;
    assign count_word = in_instr[6:0] == 7'b0010011 && in_instr[14:12] == 3'b001
                     && in_instr[31:25] == 7'b0110000 && in_instr[24:20] < 5'd3;

    p_valid_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_rd == $past(in_instr[11:7]));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_rd) && $stable(out_illegal));

    p_zero_on_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_result == '0);

    p_bad_opcode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_instr[6:0] != 7'b0010011 && in_instr[6:0] != 7'b0110011
        |=> out_illegal);

    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && count_word |=> !out_illegal && out_result <= XLEN);

endmodule

bind bitmanip_unit bitmanip_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bitmanip_unit_bench.sv
module bitmanip_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCH      = 5000;
    localparam logic [6:0] OP  = 7'b0110011;
    localparam logic [6:0] IMM = 7'b0010011;

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{enc(7'b0100000,5'd2,5'd1,3'b111,5'd3,OP),  32'hF0F01234, 32'hFF00FF00, 32'h00F00034, 1'b0, 4'd3},  // R3 andn
        '{enc(7'b0100000,5'd2,5'd1,3'b110,5'd4,OP),  32'h000000F0, 32'hFFFF0000, 32'h0000FFFF, 1'b0, 4'd3},  // R3 orn
        '{enc(7'b0100000,5'd2,5'd1,3'b100,5'd5,OP),  32'hAAAA5555, 32'hFFFF0000, 32'hAAAAAAAA, 1'b0, 4'd3},  // R3 xnor
        '{enc(7'b0000101,5'd2,5'd1,3'b100,5'd6,OP),  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b0, 4'd4},  // R4 min
        '{enc(7'b0000101,5'd2,5'd1,3'b101,5'd6,OP),  32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 4'd4},  // R4 minu
        '{enc(7'b0000101,5'd2,5'd1,3'b110,5'd6,OP),  32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 4'd4},  // R4 max
        '{enc(7'b0000101,5'd2,5'd1,3'b111,5'd6,OP),  32'h80000000, 32'h7FFFFFFF, 32'h80000000, 1'b0, 4'd4},  // R4 maxu
        '{enc(7'b0110000,5'd0,5'd1,3'b001,5'd7,IMM), 32'h00010000, 32'h0,        32'h0000000F, 1'b0, 4'd5},  // R5 clz
        '{enc(7'b0110000,5'd0,5'd1,3'b001,5'd7,IMM), 32'h00000000, 32'h0,        32'h00000020, 1'b0, 4'd5},  // R5 clz zero
        '{enc(7'b0110000,5'd1,5'd1,3'b001,5'd7,IMM), 32'h00010000, 32'h0,        32'h00000010, 1'b0, 4'd5},  // R5 ctz
        '{enc(7'b0110000,5'd1,5'd1,3'b001,5'd7,IMM), 32'h00000000, 32'h0,        32'h00000020, 1'b0, 4'd5},  // R5 ctz zero
        '{enc(7'b0110000,5'd2,5'd1,3'b001,5'd7,IMM), 32'hF0F00001, 32'h0,        32'h00000009, 1'b0, 4'd5},  // R5 cpop
        '{enc(7'b0110000,5'd2,5'd1,3'b001,5'd7,IMM), 32'hFFFFFFFF, 32'h0,        32'h00000020, 1'b0, 4'd5},  // R5 cpop full
        '{enc(7'b0110000,5'd4,5'd1,3'b001,5'd8,IMM), 32'h12345680, 32'h0,        32'hFFFFFF80, 1'b0, 4'd6},  // R6 sext byte
        '{enc(7'b0110000,5'd5,5'd1,3'b001,5'd8,IMM), 32'h00007FFF, 32'h0,        32'h00007FFF, 1'b0, 4'd6},  // R6 sext half pos
        '{enc(7'b0110000,5'd5,5'd1,3'b001,5'd8,IMM), 32'h12348001, 32'h0,        32'hFFFF8001, 1'b0, 4'd6},  // R6 sext half neg
        '{enc(7'b0110000,5'd3,5'd1,3'b001,5'd8,IMM), 32'h12345678, 32'h0,        32'h00000000, 1'b1, 4'd6},  // R6 selector 3 illegal
        '{enc(7'b0000100,5'd0,5'd1,3'b100,5'd9,OP),  32'hDEADBEEF, 32'hFFFFFFFF, 32'h0000BEEF, 1'b0, 4'd7},  // R7 zext half
        '{enc(7'b0000100,5'd1,5'd1,3'b100,5'd9,OP),  32'hDEADBEEF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd7},  // R7 rs2 nonzero
        '{enc(7'b0110000,5'd2,5'd1,3'b001,5'd10,OP), 32'h80000001, 32'h00000001, 32'h00000003, 1'b0, 4'd8},  // R8 rol wrap
        '{enc(7'b0110000,5'd2,5'd1,3'b001,5'd10,OP), 32'h12345678, 32'h00000024, 32'h23456781, 1'b0, 4'd8},  // R8 rol low 5 bits
        '{enc(7'b0110000,5'd2,5'd1,3'b101,5'd10,OP), 32'h00000001, 32'h00000001, 32'h80000000, 1'b0, 4'd8},  // R8 ror
        '{enc(7'b0110000,5'd2,5'd1,3'b101,5'd10,OP), 32'h12345678, 32'hFFFFFFE0, 32'h12345678, 1'b0, 4'd8},  // R8 ror by 0
        '{enc(7'b0110000,5'd8,5'd1,3'b101,5'd11,IMM),32'h12345678, 32'hFFFFFFFF, 32'h78123456, 1'b0, 4'd9},  // R9 rori 8
        '{enc(7'b0110001,5'd8,5'd1,3'b101,5'd11,IMM),32'h12345678, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd9},  // R9 bit25 set
        '{enc(7'b0010100,5'd7,5'd1,3'b101,5'd12,IMM),32'h00018000, 32'h0,        32'h00FFFF00, 1'b0, 4'd10}, // R10 orc
        '{enc(7'b0110100,5'd24,5'd1,3'b101,5'd12,IMM),32'h11223344,32'h0,        32'h44332211, 1'b0, 4'd10}, // R10 rev
        '{enc(7'b0000000,5'd2,5'd1,3'b000,5'd13,OP), 32'h11111111, 32'h22222222, 32'h00000000, 1'b1, 4'd11}, // R11 add word
        '{enc(7'b0110000,5'd2,5'd1,3'b001,5'd13,7'b0000011), 32'h1, 32'h1,       32'h00000000, 1'b1, 4'd11}, // R11 other opcode
        '{enc(7'b0110000,5'd2,5'd1,3'b010,5'd14,OP), 32'hFFFFFFFF, 32'h1,        32'h00000000, 1'b1, 4'd11}, // R11 rot funct3 gap
        '{enc(7'b0100000,5'd3,5'd1,3'b101,5'd14,IMM),32'hFFFFFFFF, 32'h1,        32'h00000000, 1'b1, 4'd11}, // R11 arith shift imm
        '{enc(7'b0000000,5'd3,5'd1,3'b001,5'd15,IMM),32'hFFFFFFFF, 32'h1,        32'h00000000, 1'b1, 4'd11}  // R11 shift-left imm
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_instr, in_rs1_val, in_rs2_val;
    logic        out_valid, out_illegal;
    logic [31:0] out_result;
    logic [4:0]  out_rd;

    int  n_chk  = 0;
    int  n_fail = 0;
    logic done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmanip_unit u_bitmanip_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .in_rs1_val  (in_rs1_val),
        .in_rs2_val  (in_rs2_val),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_rd      (out_rd),
        .out_illegal (out_illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        logic [31:0] keep_res;
        logic [4:0]  keep_rd;
        logic        keep_ill;
        rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_rs1_val = '0; in_rs2_val = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && out_result == 0 && out_rd == 0 && !out_illegal, "R1", "reset outputs",
              {out_result[27:0], out_valid, out_illegal, 2'b0}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && out_result == 0, "R1", "idle after reset", out_result, 32'h0);

        for (int i = 0; i < NV; i++) begin
            in_valid   = 1'b1;
            in_instr   = VECS[i].ins;
            in_rs1_val = VECS[i].a;
            in_rs2_val = VECS[i].b;
            @(negedge clk);
            n_chk++;
            if (!out_valid || out_result !== VECS[i].res || out_illegal !== VECS[i].ill
                || out_rd !== VECS[i].ins[11:7]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: result %h ill %b rd %0d vld %b, expected %h ill %b rd %0d vld 1",
                         VECS[i].req, i, out_result, out_illegal, out_rd, out_valid,
                         VECS[i].res, VECS[i].ill, VECS[i].ins[11:7]);
            end
        end

        // R2: outputs hold while no word is presented
        keep_res = out_result; keep_rd = out_rd; keep_ill = out_illegal;
        in_valid   = 1'b0;
        in_instr   = enc(7'b0100000, 5'd2, 5'd1, 3'b111, 5'd31, OP);
        in_rs1_val = 32'hFFFFFFFF;
        in_rs2_val = 32'h0;
        @(negedge clk);
        check(!out_valid, "R2", "valid drops", {31'b0, out_valid}, 32'h0);
        check(out_result == keep_res && out_rd == keep_rd && out_illegal == keep_ill,
              "R2", "held result", out_result, keep_res);

        // R2: single-cycle pulse after a gap
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_result == 32'hFFFFFFFF && out_rd == 5'd31, "R2", "pulse result",
              out_result, 32'hFFFFFFFF);
        @(negedge clk);
        check(!out_valid && out_result == 32'hFFFFFFFF, "R2", "pulse ends", {31'b0, out_valid}, 32'h0);

        // R1: reset in the middle of traffic clears everything
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!out_valid && out_result == 0 && out_rd == 0 && !out_illegal, "R1", "mid-run reset",
              out_result, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule